// File: doc/BRIEF.md
# Programmable Pixel-Period Edge Generator

This block derives the fast clock waveforms that drive an image sensor's horizontal readout and the sampling front end behind it. A 6-bit phase counter, clocked by the fast reference clock, cuts every pixel period into 64 slots. Each waveform output is set to its active level in a programmable slot and cleared in another. Each one also has its own polarity bit. Two sample strobes each give a single pulse in a programmable slot. When the reference runs at twice the pixel rate, an optional halving mode lets each slot last two reference cycles.

Configuration arrives through a plain write port. Writes update a shadow copy. The shadow copy moves to the active copy only as the phase counter wraps from 63 to 0, so a waveform never changes partway through a pixel. The bench observes the current slot on `phase_o`. The port carries no streaming data, so it has no valid/ready handshake, and a write is accepted in the cycle `cfg_we` is high.

Top module: `pix_edge_gen`

## Requirements
- R1: `phase_o` counts 0,1,…,63 and then returns to 0. With halving off, it advances on every clock.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` at `cfg_addr` in the shadow bank. The addresses are:
  - 0: reset gate.
  - 1: line-end clock.
  - 2: driver pair A.
  - 3: driver pair B.
  - 4: strobes, with the first strobe position in bits [5:0] and the second strobe position in bits [11:6].
  - 5: halving enable in bit 0.
  - For addresses 0 to 3, the fields are set slot [5:0], clear slot [11:6] and polarity [12].
- R3: A waveform's internal level is set in the clock after the first cycle of its set slot, and cleared in the clock after the first cycle of its clear slot.
- R4: When the set slot equals the clear slot, the waveform stays at its inactive level.
- R5: The output equals the internal level XOR the polarity bit, so polarity 1 makes the inactive level high.
- R6: Each strobe is high for exactly one clock: the clock after the first cycle of its programmed slot.
- R7: `h3_o` always equals `h1_o`, and `h4_o` always equals `h2_o`.
- R8: With halving active, each slot lasts two clocks, and every slot event fires once per slot.
- R9: A shadow write takes effect only from the slot-0 period that follows the next 63→0 wrap. The halving bit also takes effect only then.
- R10: After reset, `phase_o` is 0 and all outputs are at 0. The active and shadow banks hold these defaults:
  - reset gate: set 0, clear 8.
  - line-end clock: set 40, clear 60.
  - pair A: set 0, clear 32.
  - pair B: set 32, clear 0.
  - strobes: 20 and 52.
  - All polarity bits and halving are 0.
- R11: Writes to addresses 6 to 15 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 4 | Write address |
| cfg_wdata | input | 16 | Write data |
| phase_o | output | 6 | Current slot within the pixel period |
| rg_o | output | 1 | Reset gate pulse |
| hl_o | output | 1 | Line-end horizontal clock |
| h1_o | output | 1 | Driver pair A, first output |
| h2_o | output | 1 | Driver pair B, first output |
| h3_o | output | 1 | Driver pair A, second output |
| h4_o | output | 1 | Driver pair B, second output |
| shp_o | output | 1 | First sample strobe |
| shd_o | output | 1 | Second sample strobe |

## Verification
The assertions check the following on every cycle:
- the counter steps by one, or holds during the first half of a halved slot;
- a strobe never lasts two clocks;
- the active bank never changes except at a wrap;
- a waveform level follows its set and clear slots one clock later.

Some behaviour only the bench scenarios can show, by comparing every output against an independent slot-by-slot model:
- that a write made mid-pixel waits for the wrap;
- that equal set and clear slots hold the inactive level;
- that polarity inverts the output;
- that writes to unused addresses leave everything alone.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int PH_W = 6;
  localparam int N_SLOT = 1 << PH_W;

  typedef struct packed {
    logic            pol;
    logic [PH_W-1:0] clr;
    logic [PH_W-1:0] set;
  } edge_cfg_t;

  localparam int CFG_W = $bits(edge_cfg_t);

  // lane indices inside the edge bank
  localparam int LANE_RG = 0;
  localparam int LANE_HL = 1;
  localparam int LANE_HA = 2;
  localparam int LANE_HB = 3;
  localparam int N_EDGE  = 4;
  localparam int N_STRB  = 2;

  localparam edge_cfg_t DEF_RG = '{pol: 1'b0, clr: 6'd8,  set: 6'd0};
  localparam edge_cfg_t DEF_HL = '{pol: 1'b0, clr: 6'd60, set: 6'd40};
  localparam edge_cfg_t DEF_HA = '{pol: 1'b0, clr: 6'd32, set: 6'd0};
  localparam edge_cfg_t DEF_HB = '{pol: 1'b0, clr: 6'd0,  set: 6'd32};
  localparam logic [PH_W-1:0] DEF_S0 = 6'd20;
  localparam logic [PH_W-1:0] DEF_S1 = 6'd52;
endpackage

// File: rtl/pe_phase_ctr.sv
module pe_phase_ctr
  import pe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            half_en,
  output logic [PH_W-1:0] phase,
  output logic            slot_first,
  output logic            wrap
);
  localparam logic [PH_W-1:0] LAST = PH_W'(N_SLOT - 1);

  logic tog_q;
  logic adv;

  assign adv        = !half_en || tog_q;
  assign slot_first = !half_en || !tog_q;
  assign wrap       = adv && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      tog_q <= 1'b0;
    end else begin
      tog_q <= half_en ? !tog_q : 1'b0;
      if (adv) phase <= phase + PH_W'(1);
    end
  end

  // R1: without halving the slot steps by exactly one per clock
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> (phase == $past(phase) + PH_W'(1)));

  // R8: first half of a halved slot keeps the slot number
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && !tog_q) |=> $stable(phase));
endmodule

// File: rtl/pe_cfg_bank.sv
module pe_cfg_bank
  import pe_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     commit,
  output edge_cfg_t [N_EDGE-1:0]   act_edge,
  output logic [N_STRB-1:0][PH_W-1:0] act_strb,
  output logic                     act_half
);
  localparam int ADDR_STRB = N_EDGE;
  localparam int ADDR_HALF = N_EDGE + 1;

  edge_cfg_t [N_EDGE-1:0]       sh_edge;
  logic [N_STRB-1:0][PH_W-1:0]  sh_strb;
  logic                         sh_half;

  function automatic edge_cfg_t edge_default(input int idx);
    case (idx)
      LANE_RG: return DEF_RG;
      LANE_HL: return DEF_HL;
      LANE_HA: return DEF_HA;
      default: return DEF_HB;
    endcase
  endfunction

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_edge[g]  <= edge_default(g);
        act_edge[g] <= edge_default(g);
      end else begin
        if (commit) act_edge[g] <= sh_edge[g];
        if (we && addr == ADDR_W'(g)) sh_edge[g] <= wdata[CFG_W-1:0];
      end
    end
  end

  for (genvar s = 0; s < N_STRB; s++) begin : g_strb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_strb[s]  <= (s == 0) ? DEF_S0 : DEF_S1;
        act_strb[s] <= (s == 0) ? DEF_S0 : DEF_S1;
      end else begin
        if (commit) act_strb[s] <= sh_strb[s];
        if (we && addr == ADDR_W'(ADDR_STRB))
          sh_strb[s] <= wdata[s*PH_W +: PH_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_half  <= 1'b0;
      act_half <= 1'b0;
    end else begin
      if (commit) act_half <= sh_half;
      if (we && addr == ADDR_W'(ADDR_HALF)) sh_half <= wdata[0];
    end
  end

  // R9: active settings only move at a pixel wrap
  a_r9_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_edge) && $stable(act_strb) && $stable(act_half)));
endmodule

// File: rtl/pe_edge_lane.sv
module pe_edge_lane
  import pe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase,
  input  logic            slot_first,
  input  edge_cfg_t       cfg,
  output logic            lvl_o
);
  logic lvl_q;
  logic span_ok;

  assign span_ok = (cfg.set != cfg.clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (slot_first) begin
      if (!span_ok)             lvl_q <= 1'b0;
      else if (phase == cfg.set) lvl_q <= 1'b1;
      else if (phase == cfg.clr) lvl_q <= 1'b0;
    end
  end

  assign lvl_o = (lvl_q && span_ok) ^ cfg.pol;

  // R3: set slot raises the internal level on the next clock
  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_first && span_ok && phase == cfg.set) |=> lvl_q);

  // R3: clear slot drops the internal level on the next clock
  a_r3_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_first && span_ok && phase == cfg.clr) |=> !lvl_q);
endmodule

// File: rtl/pe_strobe_lane.sv
module pe_strobe_lane
  import pe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase,
  input  logic            slot_first,
  input  logic [PH_W-1:0] loc,
  output logic            pulse_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= slot_first && (phase == loc);
  end

  // R6: strobe never lasts beyond one clock
  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/pix_edge_gen.sv
module pix_edge_gen
  import pe_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [PH_W-1:0]   phase_o,
  output logic              rg_o,
  output logic              hl_o,
  output logic              h1_o,
  output logic              h2_o,
  output logic              h3_o,
  output logic              h4_o,
  output logic              shp_o,
  output logic              shd_o
);
  logic                        slot_first;
  logic                        wrap;
  logic                        half_en;
  edge_cfg_t [N_EDGE-1:0]      act_edge;
  logic [N_STRB-1:0][PH_W-1:0] act_strb;
  logic [N_EDGE-1:0]           lvl;
  logic [N_STRB-1:0]           strb;

  pe_phase_ctr u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_en    (half_en),
    .phase      (phase_o),
    .slot_first (slot_first),
    .wrap       (wrap)
  );

  pe_cfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .commit   (wrap),
    .act_edge (act_edge),
    .act_strb (act_strb),
    .act_half (half_en)
  );

  for (genvar g = 0; g < N_EDGE; g++) begin : g_lane
    pe_edge_lane u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase_o),
      .slot_first (slot_first),
      .cfg        (act_edge[g]),
      .lvl_o      (lvl[g])
    );
  end

  for (genvar s = 0; s < N_STRB; s++) begin : g_strb
    pe_strobe_lane u_strb (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase_o),
      .slot_first (slot_first),
      .loc        (act_strb[s]),
      .pulse_o    (strb[s])
    );
  end

  assign rg_o  = lvl[LANE_RG];
  assign hl_o  = lvl[LANE_HL];
  assign h1_o  = lvl[LANE_HA];
  assign h3_o  = lvl[LANE_HA];
  assign h2_o  = lvl[LANE_HB];
  assign h4_o  = lvl[LANE_HB];
  assign shp_o = strb[0];
  assign shd_o = strb[1];
endmodule

// File: tb/sim_pix_edge_gen.sv
module sim_pix_edge_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [5:0]  phase_o;
  logic rg_o, hl_o, h1_o, h2_o, h3_o, h4_o, shp_o, shd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pix_edge_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .phase_o(phase_o), .rg_o(rg_o), .hl_o(hl_o),
    .h1_o(h1_o), .h2_o(h2_o), .h3_o(h3_o), .h4_o(h4_o),
    .shp_o(shp_o), .shd_o(shd_o)
  );

  // ---- reference model built from the requirements ----
  logic [15:0] m_sh [6];
  logic [15:0] m_act [6];
  logic [5:0]  m_ph;
  logic        m_tog;
  logic [3:0]  m_lv;
  logic        m_s0, m_s1;

  function automatic logic [15:0] def_word(input int a);
    case (a)
      0: return 16'((8 << 6) | 0);
      1: return 16'((60 << 6) | 40);
      2: return 16'((32 << 6) | 0);
      3: return 16'((0 << 6) | 32);
      4: return 16'((52 << 6) | 20);
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic exp_out(input logic [15:0] w, input logic lv);
    return (lv && (w[5:0] != w[11:6])) ^ w[12];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 6; a++) begin m_sh[a] = def_word(a); m_act[a] = def_word(a); end
      m_ph = 0; m_tog = 0; m_lv = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      logic half, sf, adv, wr;
      half = m_act[5][0];
      sf   = !half || !m_tog;
      adv  = !half || m_tog;
      wr   = adv && (m_ph == 6'd63);
      for (int c = 0; c < 4; c++) begin
        if (sf) begin
          if (m_act[c][5:0] == m_act[c][11:6]) m_lv[c] = 0;
          else if (m_ph == m_act[c][5:0])      m_lv[c] = 1;
          else if (m_ph == m_act[c][11:6])     m_lv[c] = 0;
        end
      end
      m_s0 = sf && (m_ph == m_act[4][5:0]);
      m_s1 = sf && (m_ph == m_act[4][11:6]);
      m_tog = half ? !m_tog : 1'b0;
      if (adv) m_ph = m_ph + 6'd1;
      if (wr) for (int a = 0; a < 6; a++) m_act[a] = m_sh[a];
      if (cfg_we && cfg_addr < 4'd6) m_sh[cfg_addr] = cfg_wdata;
    end
  end

  task automatic chk(input string req, input string scn, input string nm,
                     input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s got %0h exp %0h", req, scn, nm, got, exp);
    end
  endtask

  task automatic check_all(input string scn);
    chk("R1", scn, "phase", phase_o, m_ph);
    chk("R3", scn, "rg", 6'(rg_o), 6'(exp_out(m_act[0], m_lv[0])));
    chk("R3", scn, "hl", 6'(hl_o), 6'(exp_out(m_act[1], m_lv[1])));
    chk("R3", scn, "h1", 6'(h1_o), 6'(exp_out(m_act[2], m_lv[2])));
    chk("R3", scn, "h2", 6'(h2_o), 6'(exp_out(m_act[3], m_lv[3])));
    chk("R7", scn, "h3", 6'(h3_o), 6'(h1_o));
    chk("R7", scn, "h4", 6'(h4_o), 6'(h2_o));
    chk("R6", scn, "shp", 6'(shp_o), 6'(m_s0));
    chk("R6", scn, "shd", 6'(shd_o), 6'(m_s1));
  endtask

  task automatic cyc(input logic we, input logic [3:0] a, input logic [15:0] d,
                     input string scn);
    @(negedge clk);
    check_all(scn);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
  endtask

  task automatic idle(input int n, input string scn);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 16'd0, scn);
  endtask

  function automatic logic [15:0] ew(input int s, input int c, input bit p);
    return 16'({p, 6'(c), 6'(s)});
  endfunction

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    // R10 reset state
    @(negedge clk); @(negedge clk);
    chk("R10", "reset", "phase", phase_o, 6'd0);
    chk("R10", "reset", "outs", {rg_o, hl_o, h1_o, h2_o, h3_o, h4_o}, 6'd0);
    chk("R10", "reset", "strb", {4'd0, shp_o, shd_o}, 6'd0);
    rst_n = 1'b1;
    idle(140, "R10 defaults");
    // R4 equal set and clear, R5 polarity
    cyc(1'b1, 4'd0, ew(10, 10, 0), "R4 equal");
    idle(140, "R4 equal");
    cyc(1'b1, 4'd1, ew(7, 7, 1), "R4 equal pol");
    idle(140, "R4 equal pol");
    cyc(1'b1, 4'd2, ew(5, 40, 1), "R5 pol");
    idle(140, "R5 pol");
    // R9 mid-pixel write waits for wrap
    idle(10, "R9 shadow");
    cyc(1'b1, 4'd3, ew(12, 50, 0), "R9 shadow");
    cyc(1'b1, 4'd4, 16'((63 << 6) | 0), "R9 shadow");
    idle(140, "R9 shadow");
    // R11 unused addresses
    for (int a = 6; a < 16; a++) cyc(1'b1, 4'(a), 16'hFFFF, "R11 unused");
    idle(140, "R11 unused");
    // R8 halving
    cyc(1'b1, 4'd5, 16'd1, "R8 half");
    idle(300, "R8 half");
    cyc(1'b1, 4'd5, 16'd0, "R8 half off");
    idle(200, "R8 half off");
    // R2 random writes with mixed modes
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 8)
        cyc(1'b1, 4'($urandom_range(0, 7)), 16'($urandom), "R2 random");
      else
        cyc(1'b0, 4'd0, 16'd0, "R2 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule